// File: doc/BRIEF.md
# Input shift register with autopush

This block is the input-side shift register of a small programmable I/O state machine. A decoder outside the block issues shift-in commands, each with a 3-bit source select and a bit-count field. The block opens a gap in its 32-bit register by shifting it left or right, as the configured direction says. It then drops the low bits of the chosen source (input pins, scratch X, scratch Y, all zeros, the register itself, or the output shift register) into that gap. The bits keep their own order whichever way the register shifts. A shift count tracks how many bits have been gathered and stops rising at the word width.

A finished word goes to a receive FIFO in one of two ways. With autopush enabled, it is written in the same cycle that the shift count reaches the configured threshold. It is also written when the decoder issues an explicit push command, which can be conditional (only at or above the threshold) and blocking or non-blocking. A blocking push, or an autopush, that meets a full FIFO stalls the machine until space is available. A non-blocking push that meets a full FIFO drops the word and sets a sticky loss flag. A restart input clears the register, the count and any stall that is pending.

Top module: `inshift_push_unit`

## Requirements
- R1: After reset the register, the shift count, the loss flag, the stall output and the FIFO write strobe are all 0.
- R2: Source select codes: 3'b000 input pins, 3'b001 X, 3'b010 Y, 3'b011 zeros, 3'b110 the register's own current value, 3'b111 the output shift register. The reserved codes 3'b100 and 3'b101 supply zeros.
- R3: A bit-count field value of 1..31 shifts that many bits, and 0 shifts 32. The shift count rises by the bit count and saturates at 32.
- R4: When the direction input is 0, the register shifts left and source bits [n-1:0] fill register bits [n-1:0]. When it is 1, the register shifts right and source bits [n-1:0] fill register bits [31:32-n].
- R5: With autopush enabled, a shift-in whose updated count is greater than or equal to the threshold (a threshold field of 0 means 32) writes the shifted word to the FIFO in the same cycle. The register and the count are then cleared.
- R6: An autopush, or a blocking push, that meets a full FIFO raises the stall output, writes nothing and leaves the register and the count unchanged.
- R7: A conditional push while the count is below the threshold does nothing: no write, no stall, no change of state.
- R8: A non-blocking push that meets a full FIFO writes nothing, clears the register and the count, and sets the sticky loss flag.
- R9: An explicit push that does not meet a full FIFO writes the current register value and clears the register and the count.
- R10: A strobe on the loss-clear input clears the loss flag. A loss in the same cycle wins, and the flag stays set.
- R11: Restart clears the register and the count, suppresses the stall and the FIFO write, and leaves the loss flag as it was.
- R12: When a shift-in and a push command arrive in the same cycle, the push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart of register, count and stall |
| cfg_shift_right_i | input | 1 | Shift direction, 1 means right |
| cfg_autopush_i | input | 1 | Autopush enable |
| cfg_thresh_i | input | 5 | Push threshold, 0 means 32 |
| in_valid_i | input | 1 | Shift-in command |
| in_src_i | input | 3 | Shift-in source select |
| in_bits_i | input | 5 | Shift-in bit count, 0 means 32 |
| push_valid_i | input | 1 | Explicit push command |
| push_cond_i | input | 1 | Push only if the count has reached the threshold |
| push_block_i | input | 1 | Push waits for FIFO space instead of dropping |
| pins_i | input | 32 | Mapped input pins |
| x_i | input | 32 | Scratch register X |
| y_i | input | 32 | Scratch register Y |
| osr_i | input | 32 | Output shift register contents |
| rx_wr_o | output | 1 | FIFO write strobe |
| rx_data_o | output | 32 | FIFO write data |
| rx_full_i | input | 1 | FIFO full |
| stall_o | output | 1 | Command must be held and retried |
| shreg_o | output | 32 | Current register contents |
| shcnt_o | output | 6 | Current shift count |
| lost_flag_o | output | 1 | Sticky flag: a word was dropped |
| lost_clr_i | input | 1 | Write-one strobe that clears the loss flag |

## Verification
Two events can fall in the same cycle: a non-blocking push that drops a word and raises the loss flag, and a loss-clear strobe. The bench issues both together and expects the flag to read 1 afterwards. A restart can also arrive while an autopush is stalled against a full FIFO. The bench applies it in the stall cycle and expects the stall output low, no write, and an empty register and count in the next cycle. A shift-in and a push issued together are judged by checking that no write happens and that only the shift took effect.

// File: rtl/inshift_pkg.sv
package inshift_pkg;

   typedef enum logic [2:0] {
      SRC_PINS = 3'b000,
      SRC_X    = 3'b001,
      SRC_Y    = 3'b010,
      SRC_ZERO = 3'b011,
      SRC_RSV4 = 3'b100,
      SRC_RSV5 = 3'b101,
      SRC_SELF = 3'b110,
      SRC_OSR  = 3'b111
   } src_sel_e;

   typedef struct packed {
      logic wr;
      logic stall;
      logic lose;
      logic clear;
      logic load;
      logic sel_shifted;
   } push_ctl_t;

endpackage

// File: rtl/inshift_src_mux.sv
module inshift_src_mux
   import inshift_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        sel_i,
   input  logic [DATA_W-1:0] pins_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] self_i,
   input  logic [DATA_W-1:0] osr_i,
   output logic [DATA_W-1:0] data_o
);

   always_comb begin
      unique case (src_sel_e'(sel_i))
         SRC_PINS: data_o = pins_i;
         SRC_X:    data_o = x_i;
         SRC_Y:    data_o = y_i;
         SRC_SELF: data_o = self_i;
         SRC_OSR:  data_o = osr_i;
         SRC_ZERO, SRC_RSV4, SRC_RSV5: data_o = '0;
         default:  data_o = '0;
      endcase
   end

endmodule

// File: rtl/inshift_datapath.sv
module inshift_datapath #(
   parameter int DATA_W = 32,
   localparam int BW = $clog2(DATA_W),
   localparam int CW = BW + 1
) (
   input  logic              shift_right_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic [CW-1:0]     cnt_i,
   input  logic [BW-1:0]     bits_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] shifted_o,
   output logic [CW-1:0]     cnt_o
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DATA_W);

   logic [CW-1:0]     nbits;
   logic [CW-1:0]     gap;
   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] src_low;
   logic [DATA_W-1:0] left_val;
   logic [DATA_W-1:0] right_val;
   logic [CW:0]       sum;

   // a zero field stands for a full word
   assign nbits = (bits_i == '0) ? FULL_CNT : {1'b0, bits_i};
   assign gap   = FULL_CNT - nbits;

   // per-bit mask of the low nbits positions
   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign keep_mask[g] = (nbits > CW'(g));
   end

   assign src_low   = src_i & keep_mask;
   assign left_val  = (reg_i << nbits) | src_low;
   assign right_val = (reg_i >> nbits) | (src_low << gap);
   assign shifted_o = shift_right_i ? right_val : left_val;

   assign sum   = {1'b0, cnt_i} + {1'b0, nbits};
   assign cnt_o = (sum > {1'b0, FULL_CNT}) ? FULL_CNT : sum[CW-1:0];

endmodule

// File: rtl/inshift_push_ctl.sv
module inshift_push_ctl
   import inshift_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic          restart_i,
   input  logic          in_valid_i,
   input  logic          autopush_i,
   input  logic          push_valid_i,
   input  logic          push_cond_i,
   input  logic          push_block_i,
   input  logic          rx_full_i,
   input  logic [CW-1:0] cnt_cur_i,
   input  logic [CW-1:0] cnt_new_i,
   input  logic [CW-1:0] thr_i,
   output push_ctl_t     ctl_o
);

   logic want_auto;
   logic explicit_cmd;
   logic cond_ok;
   logic do_explicit;

   assign want_auto    = in_valid_i && autopush_i && (cnt_new_i >= thr_i);
   assign explicit_cmd = !in_valid_i && push_valid_i;
   assign cond_ok      = !push_cond_i || (cnt_cur_i >= thr_i);
   assign do_explicit  = explicit_cmd && cond_ok;

   always_comb begin
      ctl_o.stall = !restart_i && rx_full_i &&
                    (want_auto || (do_explicit && push_block_i));
      ctl_o.wr    = !restart_i && !rx_full_i && (want_auto || do_explicit);
      ctl_o.lose  = !restart_i && rx_full_i && do_explicit && !push_block_i;
      ctl_o.clear = restart_i || ctl_o.wr || ctl_o.lose;
      ctl_o.load  = !restart_i && in_valid_i && !ctl_o.stall;
      ctl_o.sel_shifted = want_auto;
   end

endmodule

// File: rtl/inshift_push_unit.sv
module inshift_push_unit
   import inshift_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       restart_i,
   input  logic                       cfg_shift_right_i,
   input  logic                       cfg_autopush_i,
   input  logic [$clog2(DATA_W)-1:0]  cfg_thresh_i,
   input  logic                       in_valid_i,
   input  logic [2:0]                 in_src_i,
   input  logic [$clog2(DATA_W)-1:0]  in_bits_i,
   input  logic                       push_valid_i,
   input  logic                       push_cond_i,
   input  logic                       push_block_i,
   input  logic [DATA_W-1:0]          pins_i,
   input  logic [DATA_W-1:0]          x_i,
   input  logic [DATA_W-1:0]          y_i,
   input  logic [DATA_W-1:0]          osr_i,
   output logic                       rx_wr_o,
   output logic [DATA_W-1:0]          rx_data_o,
   input  logic                       rx_full_i,
   output logic                       stall_o,
   output logic [DATA_W-1:0]          shreg_o,
   output logic [$clog2(DATA_W):0]    shcnt_o,
   output logic                       lost_flag_o,
   input  logic                       lost_clr_i
);

   localparam int BW = $clog2(DATA_W);
   localparam int CW = BW + 1;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 8");
   end

   logic [DATA_W-1:0] reg_q;
   logic [CW-1:0]     cnt_q;
   logic              lost_q;
   logic [DATA_W-1:0] src_data;
   logic [DATA_W-1:0] shifted;
   logic [CW-1:0]     cnt_new;
   logic [CW-1:0]     thr_eff;
   push_ctl_t         ctl;

   assign thr_eff = (cfg_thresh_i == '0) ? CW'(DATA_W) : {1'b0, cfg_thresh_i};

   inshift_src_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i  (in_src_i),
      .pins_i (pins_i),
      .x_i    (x_i),
      .y_i    (y_i),
      .self_i (reg_q),
      .osr_i  (osr_i),
      .data_o (src_data)
   );

   inshift_datapath #(.DATA_W(DATA_W)) u_dp (
      .shift_right_i (cfg_shift_right_i),
      .reg_i         (reg_q),
      .cnt_i         (cnt_q),
      .bits_i        (in_bits_i),
      .src_i         (src_data),
      .shifted_o     (shifted),
      .cnt_o         (cnt_new)
   );

   inshift_push_ctl #(.CW(CW)) u_ctl (
      .restart_i    (restart_i),
      .in_valid_i   (in_valid_i),
      .autopush_i   (cfg_autopush_i),
      .push_valid_i (push_valid_i),
      .push_cond_i  (push_cond_i),
      .push_block_i (push_block_i),
      .rx_full_i    (rx_full_i),
      .cnt_cur_i    (cnt_q),
      .cnt_new_i    (cnt_new),
      .thr_i        (thr_eff),
      .ctl_o        (ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
         cnt_q <= '0;
      end else if (ctl.clear) begin
         reg_q <= '0;
         cnt_q <= '0;
      end else if (ctl.load) begin
         reg_q <= shifted;
         cnt_q <= cnt_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_q <= 1'b0;
      end else if (ctl.lose) begin
         lost_q <= 1'b1;
      end else if (lost_clr_i) begin
         lost_q <= 1'b0;
      end
   end

   assign rx_wr_o     = ctl.wr;
   assign rx_data_o   = ctl.sel_shifted ? shifted : reg_q;
   assign stall_o     = ctl.stall;
   assign shreg_o     = reg_q;
   assign shcnt_o     = cnt_q;
   assign lost_flag_o = lost_q;

endmodule

// File: rtl/inshift_push_unit_chk.sv
module inshift_push_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    restart_i,
   input logic                    rx_full_i,
   input logic                    rx_wr_o,
   input logic                    stall_o,
   input logic [DATA_W-1:0]       shreg_o,
   input logic [$clog2(DATA_W):0] shcnt_o,
   input logic                    lost_flag_o,
   input logic                    lost_clr_i
);

   localparam int CW = $clog2(DATA_W) + 1;

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      shcnt_o <= CW'(DATA_W)) else $error("count above word width"); // R3

   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr_o |-> !rx_full_i) else $error("write into full FIFO"); // R6

   AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> !rx_wr_o) else $error("write during stall"); // R6

   AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> ($stable(shreg_o) && $stable(shcnt_o))) else $error("state moved in stall"); // R6

   AST_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr_o |=> (shcnt_o == '0 && shreg_o == '0)) else $error("register kept after push"); // R9

   AST_RESTART_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |-> !stall_o && !rx_wr_o) else $error("restart did not cancel"); // R11

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (shcnt_o == '0 && shreg_o == '0)) else $error("restart left state"); // R11

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_flag_o && !lost_clr_i) |=> lost_flag_o) else $error("loss flag dropped"); // R10

endmodule

bind inshift_push_unit inshift_push_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_inshift_push_unit.sv
`timescale 1ns/1ps
module tb_inshift_push_unit;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, restart_i, cfg_shift_right_i, cfg_autopush_i;
   logic [4:0]  cfg_thresh_i, in_bits_i;
   logic        in_valid_i, push_valid_i, push_cond_i, push_block_i;
   logic [2:0]  in_src_i;
   logic [31:0] pins_i, x_i, y_i, osr_i, rx_data_o, shreg_o;
   logic        rx_wr_o, rx_full_i, stall_o, lost_flag_o, lost_clr_i;
   logic [5:0]  shcnt_o;

   inshift_push_unit #(.DATA_W(32)) dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_reg;
   int          m_cnt;
   bit          m_lost;
   bit          m_last_wr;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cmd(input bit iv, input logic [2:0] src, input logic [4:0] bits,
                      input bit pv, input bit pc, input bit pb,
                      input bit full, input bit clr, input bit rst, input string req);
      int n, nc, te;
      logic [31:0] sv, sh, ed;
      bit auto_p, expl, e_stall, e_wr, e_lose;
      @(negedge clk);
      in_valid_i = iv; in_src_i = src; in_bits_i = bits;
      push_valid_i = pv; push_cond_i = pc; push_block_i = pb;
      rx_full_i = full; lost_clr_i = clr; restart_i = rst;
      n = (bits == 0) ? 32 : int'(bits);
      case (src)
         3'b000: sv = pins_i;
         3'b001: sv = x_i;
         3'b010: sv = y_i;
         3'b110: sv = m_reg;
         3'b111: sv = osr_i;
         default: sv = 32'h0;
      endcase
      if (cfg_shift_right_i) begin
         sh = (n == 32) ? 32'h0 : (m_reg >> n);
         for (int i = 0; i < n; i++) sh[32-n+i] = sv[i];
      end else begin
         sh = (n == 32) ? 32'h0 : (m_reg << n);
         for (int i = 0; i < n; i++) sh[i] = sv[i];
      end
      nc = m_cnt + n;
      if (nc > 32) nc = 32;
      te = (cfg_thresh_i == 0) ? 32 : int'(cfg_thresh_i);
      auto_p  = iv && cfg_autopush_i && (nc >= te);
      expl    = !iv && pv && (!pc || m_cnt >= te);
      e_stall = !rst && full && (auto_p || (expl && pb));
      e_wr    = !rst && !full && (auto_p || expl);
      e_lose  = !rst && full && expl && !pb;
      ed      = auto_p ? sh : m_reg;
      #1;
      chk(stall_o == e_stall, req, "stall", 32'(stall_o), 32'(e_stall));
      chk(rx_wr_o == e_wr, req, "write", 32'(rx_wr_o), 32'(e_wr));
      if (e_wr) chk(rx_data_o == ed, req, "wdata", rx_data_o, ed);
      if (rst || e_wr || e_lose) begin
         m_reg = 32'h0; m_cnt = 0;
      end else if (iv && !e_stall) begin
         m_reg = sh; m_cnt = nc;
      end
      if (e_lose) m_lost = 1'b1;
      else if (clr) m_lost = 1'b0;
      m_last_wr = e_wr;
      @(posedge clk);
      #1;
      chk(shreg_o == m_reg, req, "register", shreg_o, m_reg);
      chk(int'(shcnt_o) == m_cnt, req, "count", 32'(shcnt_o), 32'(m_cnt));
      chk(lost_flag_o == m_lost, req, "lossflag", 32'(lost_flag_o), 32'(m_lost));
   endtask

   task automatic restart_now();
      cmd(1'b0, 3'b000, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      rst_n = 1'b0; restart_i = 1'b0; cfg_shift_right_i = 1'b0; cfg_autopush_i = 1'b0;
      cfg_thresh_i = 5'd0; in_valid_i = 1'b0; in_src_i = 3'b000; in_bits_i = 5'd0;
      push_valid_i = 1'b0; push_cond_i = 1'b0; push_block_i = 1'b0;
      rx_full_i = 1'b0; lost_clr_i = 1'b0;
      pins_i = 32'hA5C3_1E7F; x_i = 32'h1234_5678; y_i = 32'h9ABC_DEF0; osr_i = 32'h0F1E_2D3C;
      m_reg = 32'h0; m_cnt = 0; m_lost = 1'b0; m_last_wr = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(shreg_o == 32'h0, "R1", "register", shreg_o, 32'h0);
      chk(shcnt_o == 6'd0, "R1", "count", 32'(shcnt_o), 32'h0);
      chk(lost_flag_o == 1'b0, "R1", "lossflag", 32'(lost_flag_o), 32'h0);
      chk(stall_o == 1'b0, "R1", "stall", 32'(stall_o), 32'h0);
      chk(rx_wr_o == 1'b0, "R1", "write", 32'(rx_wr_o), 32'h0);
      rst_n = 1'b1;

      // R3 R4 sweep of both directions and every bit-count field
      for (int d = 0; d < 2; d++) begin
         cfg_shift_right_i = d[0];
         for (int f = 0; f < 32; f++) begin
            restart_now();
            cmd(1'b1, 3'b001, 5'(f), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
            cmd(1'b1, 3'b010, 5'((f * 7 + 3) % 32), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
         end
      end

      // R2 every source code in both directions
      for (int d = 0; d < 2; d++) begin
         cfg_shift_right_i = d[0];
         for (int s = 0; s < 8; s++) begin
            restart_now();
            cmd(1'b1, 3'b111, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
            cmd(1'b1, 3'(s), 5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
         end
      end

      // R3 saturation of the count
      cfg_shift_right_i = 1'b0;
      restart_now();
      cmd(1'b1, 3'b000, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      cmd(1'b1, 3'b000, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      cmd(1'b1, 3'b001, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

      // R5 autopush at every threshold value
      cfg_autopush_i = 1'b1;
      for (int d = 0; d < 2; d++) begin
         cfg_shift_right_i = d[0];
         for (int t = 0; t < 32; t++) begin
            cfg_thresh_i = 5'(t);
            restart_now();
            for (int k = 0; k < 12; k++) begin
               cmd(1'b1, 3'b000, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
               if (m_last_wr) break;
            end
            chk(m_last_wr, "R5", "autopush seen", 32'(m_last_wr), 32'h1);
         end
      end

      // R6 autopush into full FIFO stalls, then drains
      cfg_shift_right_i = 1'b0; cfg_thresh_i = 5'd8;
      restart_now();
      cmd(1'b1, 3'b001, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      cmd(1'b1, 3'b010, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      cmd(1'b1, 3'b010, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      cmd(1'b1, 3'b010, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

      // R11 restart lands on a stalled autopush
      cmd(1'b1, 3'b001, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      cmd(1'b1, 3'b010, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R11");

      // explicit push commands, autopush off
      cfg_autopush_i = 1'b0;
      restart_now();
      cmd(1'b1, 3'b001, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      cmd(1'b0, 3'b000, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
      cmd(1'b1, 3'b010, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      cmd(1'b0, 3'b000, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
      cmd(1'b1, 3'b000, 5'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      cmd(1'b0, 3'b000, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
      cmd(1'b0, 3'b000, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
      cmd(1'b0, 3'b000, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      restart_now();
      cmd(1'b0, 3'b000, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
      cmd(1'b1, 3'b111, 5'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      cmd(1'b0, 3'b000, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
      cmd(1'b0, 3'b000, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10");

      // R12 shift and push together: only the shift happens
      restart_now();
      cmd(1'b1, 3'b001, 5'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
      cmd(1'b1, 3'b010, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
      cmd(1'b1, 3'b000, 5'd8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R12");

      @(negedge clk);
      in_valid_i = 1'b0; push_valid_i = 1'b0; rx_full_i = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule